// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit control and status words reached over a plain word-access bus with a byte address, read and write strobes, write data and registered read data. Most of the bank can only be written after software has written a magic unlock value to the key word at offset 0x000. A write of any other value to the key word locks the bank again. A handful of words are status only and refuse writes. One word returns a fresh pseudo-random number on every read.

A strap word can be built up bit by bit through one address and torn down through a second address. This holds in the set/clear build variant only. In the plain variant, the strap word is an ordinary store and the second address refuses writes. Every write that the bank drops raises a one-cycle error pulse.

At reset each word takes a fixed default. Then the revision word, two strap words and the key word are loaded from input pins.

Top module: `sysctl_keyed_regs`

## Requirements
- R1: The word index is `bus_addr >> 2`. A write whose `bus_addr[1:0]` is not zero changes nothing and is flagged. A read whose `bus_addr[1:0]` is not zero returns 0.
- R2: A write to offset 0x000 (the key word) is accepted even while the bank is locked. It stores 1 when the data equals `MAGIC` (default 32'h1688_A8A8) and 0 for any other data. Reading the key word returns the stored value.
- R3: While the key word holds 0, writes to offsets 0x004 to 0x100 are dropped and flagged. Offsets from 0x104 upward stay writable while locked.
- R4: Writes to the status-only words are dropped and flagged, and the word keeps its value. The status-only words are 0x014, 0x050 to 0x06C, 0x078, 0x0E0 and 0x0E4.
- R5: With `STRAP_SET_CLEAR` = 1, a write to 0x070 ORs the data into the strap word. A write to 0x07C clears the strap-word bits that are 1 in the data and leaves the revision word unchanged.
- R6: With `STRAP_SET_CLEAR` = 0, a write to 0x070 is a plain store. A write to 0x07C is dropped and flagged.
- R7: Each read of 0x078 returns the current generator state and then advances it to `(s >> 1) ^ (s[0] ? 32'h8020_0003 : 0)`. This happens regardless of the value of any other word. The first read after reset returns `RNG_SEED` (default 32'h1234_5678, nonzero).
- R8: For indices at or above `NUM_WORDS` (default 128, i.e. offsets 0x200 and up), reads return 0 and writes are dropped and flagged.
- R9: `bus_rdata` takes the read result on the clock edge that samples `bus_rd` and holds it until the next read. A read in the same cycle as a write to the same word returns the old contents.
- R10: After reset, `bus_rdata` is 0 and `wr_err` is 0. Word 0x004 is 32'hA5A5_0001, word 0x02C is 32'h0000_0010, and words 0x0E0 and 0x0E4 are 32'h0000_00FF. Word 0x07C is `rev_id_in`, 0x070 is `strap_a_in`, 0x0D0 is `strap_b_in` and 0x000 is `key_init_in`. Every other word is 0.
- R11: `wr_err` is high for exactly the one cycle after a dropped write. It is low after accepted writes and after cycles without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wr_err | output | 1 | Pulse marking a dropped write |
| rev_id_in | input | 32 | Revision value loaded at reset |
| strap_a_in | input | 32 | Strap word A loaded at reset |
| strap_b_in | input | 32 | Strap word B loaded at reset |
| key_init_in | input | 32 | Key word value loaded at reset |

## Verification
Several properties are checked on every cycle:
- a locked, status-only, misaligned or out-of-range write is followed by an error pulse;
- a key write opens or closes the bank according to its data;
- out-of-range reads give zero;
- the read data holds between reads;
- the generator stays nonzero and moves on each random-word read.

The bench scenarios cover the rest: the exact reset contents, the set/clear and plain strap behaviour, the generator sequence, and the old-data result of a read that collides with a write. They compare both build variants against a behavioural model cycle by cycle.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;

  typedef enum logic [2:0] {
    WACT_NONE,
    WACT_STORE,
    WACT_KEY,
    WACT_STRAP_OR,
    WACT_STRAP_CLR,
    WACT_DROP
  } wr_act_e;

  // Word indices whose behaviour depends on position
  localparam int IDX_KEY      = 0;
  localparam int IDX_RSTCTL   = 1;
  localparam int IDX_FCNT     = 5;
  localparam int IDX_MISC     = 11;
  localparam int IDX_SCR_LO   = 20;
  localparam int IDX_SCR_HI   = 27;
  localparam int IDX_STRAP_A  = 28;
  localparam int IDX_RNG      = 30;
  localparam int IDX_REV      = 31;
  localparam int IDX_STRAP_B  = 52;
  localparam int IDX_FREE0    = 56;
  localparam int IDX_FREE1    = 57;
  localparam int IDX_LOCK_END = 65;

  function automatic logic [31:0] reset_word(int idx);
    case (idx)
      IDX_RSTCTL: reset_word = 32'hA5A5_0001;
      IDX_MISC:   reset_word = 32'h0000_0010;
      IDX_FREE0,
      IDX_FREE1:  reset_word = 32'h0000_00FF;
      default:    reset_word = 32'h0;
    endcase
  endfunction

  function automatic logic is_read_only(int idx);
    is_read_only = (idx == IDX_FCNT) || (idx == IDX_RNG) ||
                   (idx == IDX_FREE0) || (idx == IDX_FREE1) ||
                   ((idx >= IDX_SCR_LO) && (idx <= IDX_SCR_HI));
  endfunction

endpackage

// File: rtl/sysctl_rng.sv
`timescale 1ns/1ps
module sysctl_rng #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h1234_5678
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] nxt;

  // Galois form: one XOR level regardless of tap count
  always_comb begin
    nxt = {1'b0, state[W-1:1]};
    if (state[0]) nxt = nxt ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (step) state <= nxt;
  end

endmodule

// File: rtl/sysctl_write_ctl.sv
`timescale 1ns/1ps
module sysctl_write_ctl
  import sysctl_pkg::*;
#(
  parameter int IDX_W           = 10,
  parameter int NUM_WORDS       = 128,
  parameter bit STRAP_SET_CLEAR = 1'b1
) (
  input  logic             wr,
  input  logic             aligned,
  input  logic [IDX_W-1:0] idx,
  input  logic             key_open,
  output wr_act_e          act
);

  int      widx;
  wr_act_e strap_act;
  wr_act_e rev_act;

  assign widx = int'(32'(idx));

  generate
    if (STRAP_SET_CLEAR) begin : g_setclr
      assign strap_act = WACT_STRAP_OR;
      assign rev_act   = WACT_STRAP_CLR;
    end else begin : g_plain
      assign strap_act = WACT_STORE;
      assign rev_act   = WACT_DROP;
    end
  endgenerate

  // Priority: alignment/range, key, lock, status-only, special words
  always_comb begin
    if (!wr)                                        act = WACT_NONE;
    else if (!aligned || (widx >= NUM_WORDS))       act = WACT_DROP;
    else if (widx == IDX_KEY)                       act = WACT_KEY;
    else if (!key_open && (widx < IDX_LOCK_END))    act = WACT_DROP;
    else if (is_read_only(widx))                    act = WACT_DROP;
    else if (widx == IDX_STRAP_A)                   act = strap_act;
    else if (widx == IDX_REV)                       act = rev_act;
    else                                            act = WACT_STORE;
  end

endmodule

// File: rtl/sysctl_regfile.sv
`timescale 1ns/1ps
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int          NUM_WORDS = 128,
  parameter int          IDX_W     = 10,
  parameter logic [31:0] MAGIC     = 32'h1688_A8A8,
  localparam int         MEM_AW    = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_act_e          act,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  input  logic [31:0]      rev_id_in,
  input  logic [31:0]      strap_a_in,
  input  logic [31:0]      strap_b_in,
  input  logic [31:0]      key_init_in,
  output logic [31:0]      rd_word,
  output logic             key_open
);

  logic [31:0]       mem [NUM_WORDS];
  logic [MEM_AW-1:0] slot;
  logic              in_range;

  assign slot     = idx[MEM_AW-1:0];
  assign in_range = (32'(idx) < NUM_WORDS);
  assign key_open = |mem[IDX_KEY];
  assign rd_word  = in_range ? mem[slot] : 32'h0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= reset_word(i);
      mem[IDX_REV]     <= rev_id_in;
      mem[IDX_STRAP_A] <= strap_a_in;
      mem[IDX_STRAP_B] <= strap_b_in;
      mem[IDX_KEY]     <= key_init_in;
    end else begin
      case (act)
        WACT_STORE:     mem[slot]        <= wdata;
        WACT_KEY:       mem[IDX_KEY]     <= (wdata == MAGIC) ? 32'd1 : 32'd0;
        WACT_STRAP_OR:  mem[IDX_STRAP_A] <= mem[IDX_STRAP_A] | wdata;
        WACT_STRAP_CLR: mem[IDX_STRAP_A] <= mem[IDX_STRAP_A] & ~wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sysctl_keyed_regs.sv
`timescale 1ns/1ps
module sysctl_keyed_regs
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W          = 12,
  parameter int          NUM_WORDS       = 128,
  parameter logic [31:0] MAGIC           = 32'h1688_A8A8,
  parameter logic [31:0] RNG_SEED        = 32'h1234_5678,
  parameter bit          STRAP_SET_CLEAR = 1'b1,
  localparam int         IDX_W           = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wr_err,
  input  logic [31:0]       rev_id_in,
  input  logic [31:0]       strap_a_in,
  input  logic [31:0]       strap_b_in,
  input  logic [31:0]       key_init_in
);

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             in_range;
  logic             rng_hit;
  logic             key_open;
  logic [31:0]      rd_word;
  logic [31:0]      rng_state;
  wr_act_e          act;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign in_range = (32'(idx) < NUM_WORDS);
  assign rng_hit  = bus_rd && aligned && (32'(idx) == IDX_RNG);

  sysctl_write_ctl #(
    .IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS), .STRAP_SET_CLEAR(STRAP_SET_CLEAR)
  ) u_write_ctl (
    .wr(bus_wr), .aligned(aligned), .idx(idx), .key_open(key_open), .act(act)
  );

  sysctl_regfile #(
    .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .MAGIC(MAGIC)
  ) u_regfile (
    .clk(clk), .rst(rst), .act(act), .idx(idx), .wdata(bus_wdata),
    .rev_id_in(rev_id_in), .strap_a_in(strap_a_in), .strap_b_in(strap_b_in),
    .key_init_in(key_init_in), .rd_word(rd_word), .key_open(key_open)
  );

  sysctl_rng #(.W(32), .TAPS(32'h8020_0003), .SEED(RNG_SEED)) u_rng (
    .clk(clk), .rst(rst), .step(rng_hit), .state(rng_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 32'h0;
      wr_err    <= 1'b0;
    end else begin
      wr_err <= (act == WACT_DROP);
      if (bus_rd) begin
        if (!aligned || !in_range) bus_rdata <= 32'h0;
        else if (rng_hit)          bus_rdata <= rng_state;
        else                       bus_rdata <= rd_word;
      end
    end
  end

endmodule

// File: rtl/sysctl_keyed_regs_chk.sv
`timescale 1ns/1ps
module sysctl_keyed_regs_chk
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          NUM_WORDS = 128,
  parameter logic [31:0] MAGIC     = 32'h1688_A8A8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              wr_err,
  input logic              key_open,
  input logic [31:0]       rng_state
);

  int   c_idx;
  logic c_al;
  logic c_oor;

  assign c_idx = int'(32'(bus_addr[ADDR_W-1:2]));
  assign c_al  = (bus_addr[1:0] == 2'b00);
  assign c_oor = !c_al || (c_idx >= NUM_WORDS);

  AST_BAD_ADDR_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    bus_wr && c_oor |=> wr_err); // R8
  AST_BAD_ADDR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rd && c_oor |=> bus_rdata == 32'h0); // R1
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
    bus_wr && c_al && c_idx == IDX_KEY && bus_wdata == MAGIC |=> key_open); // R2
  AST_KEY_CLOSES: assert property (@(posedge clk) disable iff (rst)
    bus_wr && c_al && c_idx == IDX_KEY && bus_wdata != MAGIC |=> !key_open); // R2
  AST_LOCKED_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    bus_wr && c_al && !key_open && c_idx > IDX_KEY && c_idx < IDX_LOCK_END |=> wr_err); // R3
  AST_STATUS_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    bus_wr && c_al && is_read_only(c_idx) |=> wr_err); // R4
  AST_RNG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    rng_state != 32'h0); // R7
  AST_RNG_MOVES: assert property (@(posedge clk) disable iff (rst)
    bus_rd && c_al && c_idx == IDX_RNG |=> rng_state != $past(rng_state)); // R7
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R9
  AST_NO_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> !wr_err); // R11

endmodule

bind sysctl_keyed_regs sysctl_keyed_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .MAGIC(MAGIC)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_err(wr_err),
  .key_open(key_open), .rng_state(rng_state)
);

// File: tb/sysctl_keyed_regs_bench.sv
`timescale 1ns/1ps
module sysctl_keyed_regs_bench;

  localparam int          NW   = 128;
  localparam logic [31:0] KEY  = 32'h1688_A8A8;
  localparam logic [31:0] SEED = 32'h1234_5678;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rev = 32'h0403_0303, sa = 32'h0000_0105, sb = 32'h0000_0022;
  logic [31:0] kinit = 32'h0;
  logic [31:0] rdata [2];
  logic        err [2];

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] m [2][NW];
  logic [31:0] lf [2];
  logic [31:0] exp_rd [2];
  logic        exp_err [2];

  always #2.5 clk = ~clk;

  // index 0: set/clear variant, index 1: plain variant
  sysctl_keyed_regs #(.STRAP_SET_CLEAR(1'b1)) u_sysctl_keyed_regs (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata[0]), .wr_err(err[0]),
    .rev_id_in(rev), .strap_a_in(sa), .strap_b_in(sb), .key_init_in(kinit));

  sysctl_keyed_regs #(.STRAP_SET_CLEAR(1'b0)) u_sysctl_keyed_regs_plain (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata[1]), .wr_err(err[1]),
    .rev_id_in(rev), .strap_a_in(sa), .strap_b_in(sb), .key_init_in(kinit));

  function automatic void model_reset();
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < NW; i++) m[k][i] = 32'h0;
      m[k][1]  = 32'hA5A5_0001;
      m[k][11] = 32'h0000_0010;
      m[k][56] = 32'h0000_00FF;
      m[k][57] = 32'h0000_00FF;
      m[k][31] = rev;
      m[k][28] = sa;
      m[k][52] = sb;
      m[k][0]  = kinit;
      lf[k] = SEED;
      exp_rd[k] = 32'h0;
      exp_err[k] = 1'b0;
    end
  endfunction

  function automatic bit status_only(int i);
    return i == 5 || i == 30 || i == 56 || i == 57 || (i >= 20 && i <= 27);
  endfunction

  function automatic void model_step(bit r, bit w, logic [11:0] a, logic [31:0] d);
    int  i;
    bit  ok;
    i  = int'(a >> 2);
    ok = (a[1:0] == 2'b00) && (i < NW);
    for (int k = 0; k < 2; k++) begin
      if (r) begin
        if (!ok)          exp_rd[k] = 32'h0;
        else if (i == 30) begin
          exp_rd[k] = lf[k];
          if (lf[k][0]) lf[k] = (lf[k] >> 1) ^ 32'h8020_0003;
          else          lf[k] = lf[k] >> 1;
        end
        else exp_rd[k] = m[k][i];
      end
      exp_err[k] = 1'b0;
      if (w) begin
        if (!ok)                           exp_err[k] = 1'b1;
        else if (i == 0)                   m[k][0] = (d == KEY) ? 32'd1 : 32'd0;
        else if (m[k][0] == 0 && i <= 64)  exp_err[k] = 1'b1;
        else if (status_only(i))           exp_err[k] = 1'b1;
        else if (i == 28 && k == 0)        m[k][28] = m[k][28] | d;
        else if (i == 31) begin
          if (k == 0) m[k][28] = m[k][28] & ~d;
          else        exp_err[k] = 1'b1;
        end
        else m[k][i] = d;
      end
    end
  endfunction

  task automatic compare(string tag);
    for (int k = 0; k < 2; k++) begin
      checks++;
      if (rdata[k] !== exp_rd[k]) begin
        fails++;
        $display("FAIL %s dut%0d bus_rdata actual %h expected %h", tag, k, rdata[k], exp_rd[k]);
      end
      checks++;
      if (err[k] !== exp_err[k]) begin
        fails++;
        $display("FAIL %s dut%0d wr_err actual %b expected %b", tag, k, err[k], exp_err[k]);
      end
    end
  endtask

  // Called at a falling edge; drives, steps the model, checks after the rise
  task automatic cyc(bit r, bit w, logic [11:0] a, logic [31:0] d, string tag);
    rd = r; wr = w; addr = a; wdata = d;
    model_step(r, w, a, d);
    @(posedge clk);
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic wr_w(logic [11:0] a, logic [31:0] d, string tag);
    cyc(1'b0, 1'b1, a, d, tag);
  endtask

  task automatic rd_w(logic [11:0] a, string tag);
    cyc(1'b1, 1'b0, a, 32'h0, tag);
  endtask

  task automatic do_reset(logic [31:0] kin);
    rst = 1'b1; rd = 1'b0; wr = 1'b0; kinit = kin;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    #0.5;
    compare("R10");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(32'h0);
    // R10 reset contents
    rd_w(12'h000, "R10"); rd_w(12'h004, "R10"); rd_w(12'h02C, "R10");
    rd_w(12'h070, "R10"); rd_w(12'h07C, "R10"); rd_w(12'h0D0, "R10");
    rd_w(12'h0E0, "R10"); rd_w(12'h0E4, "R10"); rd_w(12'h008, "R10");
    // R3 lock window
    wr_w(12'h008, 32'hDEAD_0001, "R3"); rd_w(12'h008, "R3");
    wr_w(12'h100, 32'hDEAD_0002, "R3"); rd_w(12'h100, "R3");
    wr_w(12'h104, 32'hBEEF_0003, "R3"); rd_w(12'h104, "R3");
    // R2 key behaviour
    wr_w(12'h000, 32'h1688_A8A9, "R2"); rd_w(12'h000, "R2");
    wr_w(12'h008, 32'h0000_0011, "R2");
    wr_w(12'h000, KEY, "R2"); rd_w(12'h000, "R2");
    wr_w(12'h008, 32'h0000_0022, "R11"); rd_w(12'h008, "R11");
    // R4 status-only words
    wr_w(12'h014, 32'h1, "R4"); wr_w(12'h050, 32'h2, "R4");
    wr_w(12'h06C, 32'h3, "R4"); wr_w(12'h078, 32'h4, "R4");
    wr_w(12'h0E0, 32'h5, "R4"); wr_w(12'h0E4, 32'h6, "R4");
    rd_w(12'h0E0, "R4"); rd_w(12'h050, "R4"); rd_w(12'h014, "R4");
    // R5 / R6 strap handling
    wr_w(12'h070, 32'h0000_00F0, "R5"); rd_w(12'h070, "R6");
    wr_w(12'h07C, 32'h0000_0030, "R5"); rd_w(12'h070, "R5");
    rd_w(12'h07C, "R6");
    // R7 random word, control word cleared first
    wr_w(12'h074, 32'h0, "R7");
    for (int n = 0; n < 5; n++) rd_w(12'h078, "R7");
    // R8 out of range
    rd_w(12'h200, "R8"); rd_w(12'hFFC, "R8");
    wr_w(12'h204, 32'h7777_7777, "R8"); rd_w(12'h004, "R8");
    // R1 misaligned
    wr_w(12'h00A, 32'h5555_5555, "R1"); rd_w(12'h008, "R1");
    rd_w(12'h005, "R1");
    // R9 read/write collision and hold
    cyc(1'b1, 1'b1, 12'h010, 32'hC0DE_0010, "R9");
    cyc(1'b0, 1'b0, 12'h000, 32'h0, "R9");
    cyc(1'b0, 1'b0, 12'h010, 32'h0, "R9");
    rd_w(12'h010, "R9");
    // relock
    wr_w(12'h000, 32'h0, "R2"); wr_w(12'h030, 32'h1, "R3");
    rd_w(12'h030, "R3");
    // R10 reset with a nonzero key load
    do_reset(32'h0000_0005);
    rd_w(12'h000, "R10"); rd_w(12'h078, "R10");
    wr_w(12'h008, 32'h0000_0099, "R10"); rd_w(12'h008, "R10");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule